// File: doc/BRIEF.md
# Two-Port Column-Masked Synchronous RAM

This block is a single-clock memory with two symmetric access ports, A and B. Each port carries its own address, write data, a per-column write-enable vector and a registered read-data output. A write on a port updates only the columns whose enable bits are set. The other columns of that word keep their stored value. Read data leaves through a register, one clock after the address is presented, in the way an inferred block RAM with a registered output behaves.

A per-port parameter sets what a writing port returns. In NEW mode it returns the word as it stands after the write. In OLD mode it returns the word as it stood before the write. Contents are preset at elaboration, either by copying one scalar into every word or from a packed list that holds one value per address. Reset clears only the two output registers and leaves the stored words alone, so any clearing of contents must be done with explicit writes. The two ports must never use the same address in the same cycle. The result of that case is undefined.

Top module: `tdp_col_ram`

## Requirements
- R1: A port whose enable bits are all set replaces the whole word at its address, and a later read of that address on either port returns the new value.
- R2: Read data appears on a port's output exactly one clock edge after the address is sampled.
- R3: A write with a partial enable vector changes only the columns whose enable bit is 1. Enable bit c covers data bits [c*COL_W +: COL_W], with COL_W = DATA_W / NUM_COLS. The other columns keep their previous value.
- R4: A port in NEW mode that writes shows the merged post-write word on its output one cycle later.
- R5: A port in OLD mode that writes shows the word held before the write on its output one cycle later.
- R6: A port that does not write (enable vector all zero) shows the word stored at its address, whatever its mode.
- R7: With per-word initialisation selected, word i starts as INIT_LIST[i*DATA_W +: DATA_W].
- R8: With scalar initialisation selected, every word starts as INIT_SCALAR.
- R9: While rst_ni is low both read outputs are zero, and memory contents written before the reset are still readable after it.
- R10: The two ports write to different addresses in the same cycle without interfering with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the output registers only |
| we_a_i | input | NUM_COLS | Port A column write enables |
| addr_a_i | input | ADDR_W | Port A address |
| wdata_a_i | input | DATA_W | Port A write data |
| rdata_a_o | output | DATA_W | Port A registered read data |
| we_b_i | input | NUM_COLS | Port B column write enables |
| addr_b_i | input | ADDR_W | Port B address |
| wdata_b_i | input | DATA_W | Port B write data |
| rdata_b_o | output | DATA_W | Port B registered read data |

## Verification
The assertions assume that ports A and B never present the same address in the same cycle. The column-preservation and output checks compare one port's result with the memory word, and that word could otherwise be changed by the other port. The stimulus picks port B's address as port A's address XORed with a non-zero value, so the two addresses always differ. About a quarter of the cycles leave a port idle, so that reads, partial writes and full writes all occur. The directed cases cover the address extremes, a reset in the middle of the run, and an instance with scalar initialisation.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
  typedef enum logic {
    RDW_NEW = 1'b0,
    RDW_OLD = 1'b1
  } rdw_mode_e;
endpackage

// File: rtl/tdp_col_mask.sv
module tdp_col_mask #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_COLS = 4
) (
  input  logic [NUM_COLS-1:0] col_en_i,
  output logic [DATA_W-1:0]   bit_en_o
);
  localparam int unsigned COL_W = DATA_W / NUM_COLS;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign bit_en_o[c*COL_W +: COL_W] = {COL_W{col_en_i[c]}};
  end
endmodule

// File: rtl/tdp_rd_reg.sv
module tdp_rd_reg
  import tdp_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter rdw_mode_e   MODE   = RDW_NEW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] stored_i,
  input  logic [DATA_W-1:0] merged_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_d;

  if (MODE == RDW_NEW) begin : g_new
    assign rd_d = wr_i ? merged_i : stored_i;
  end else begin : g_old
    assign rd_d = stored_i;
    logic unused_new;
    assign unused_new = ^{wr_i, merged_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

  // R9: output starts from zero when reset is released
  p_rst_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> rdata_o == '0);
endmodule

// File: rtl/tdp_col_ram.sv
module tdp_col_ram
  import tdp_ram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned NUM_COLS      = 4,
  parameter rdw_mode_e   MODE_A        = RDW_NEW,
  parameter rdw_mode_e   MODE_B        = RDW_OLD,
  parameter bit          INIT_PER_WORD = 1'b0,
  parameter logic [DATA_W-1:0] INIT_SCALAR = '0,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] INIT_LIST = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_COLS-1:0] we_a_i,
  input  logic [ADDR_W-1:0]   addr_a_i,
  input  logic [DATA_W-1:0]   wdata_a_i,
  output logic [DATA_W-1:0]   rdata_a_o,
  input  logic [NUM_COLS-1:0] we_b_i,
  input  logic [ADDR_W-1:0]   addr_b_i,
  input  logic [DATA_W-1:0]   wdata_b_i,
  output logic [DATA_W-1:0]   rdata_b_o
);
  localparam int unsigned DEPTH   = 2**ADDR_W;
  localparam int unsigned COL_W   = DATA_W / NUM_COLS;
  localparam int unsigned N_PORTS = 2;

  if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_addr
    $error("ADDR_W must lie in 2..31");
  end
  if (NUM_COLS == 0 || (DATA_W % NUM_COLS) != 0) begin : g_bad_cols
    $error("DATA_W must be a multiple of NUM_COLS");
  end

  typedef logic [DATA_W-1:0] word_t;
  typedef word_t mem_t [DEPTH];

  function automatic mem_t init_fn();
    mem_t m;
    for (int i = 0; i < DEPTH; i++)
      m[i] = INIT_PER_WORD ? INIT_LIST[i*DATA_W +: DATA_W] : INIT_SCALAR;
    return m;
  endfunction

  // contents are preset at elaboration and never touched by reset
  mem_t mem = init_fn();

  logic [NUM_COLS-1:0] we     [N_PORTS];
  logic [ADDR_W-1:0]   addr   [N_PORTS];
  word_t               wdata  [N_PORTS];
  word_t               rdata  [N_PORTS];
  word_t               bit_en [N_PORTS];
  word_t               stored [N_PORTS];
  word_t               merged [N_PORTS];
  logic                wr_any [N_PORTS];

  assign we[0]    = we_a_i;
  assign addr[0]  = addr_a_i;
  assign wdata[0] = wdata_a_i;
  assign we[1]    = we_b_i;
  assign addr[1]  = addr_b_i;
  assign wdata[1] = wdata_b_i;
  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    localparam rdw_mode_e PMODE = (p == 0) ? MODE_A : MODE_B;

    tdp_col_mask #(
      .DATA_W  (DATA_W),
      .NUM_COLS(NUM_COLS)
    ) i_mask (
      .col_en_i(we[p]),
      .bit_en_o(bit_en[p])
    );

    assign wr_any[p] = |we[p];
    assign stored[p] = mem[addr[p]];
    assign merged[p] = (stored[p] & ~bit_en[p]) | (wdata[p] & bit_en[p]);

    tdp_rd_reg #(
      .DATA_W(DATA_W),
      .MODE  (PMODE)
    ) i_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_any[p]),
      .stored_i(stored[p]),
      .merged_i(merged[p]),
      .rdata_o (rdata[p])
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col_chk
      // R1: enabled column takes the write data
      p_col_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we[p][c] |=> mem[$past(addr[p])][c*COL_W +: COL_W]
                     == $past(wdata[p][c*COL_W +: COL_W]));
      // R3: disabled column keeps its value
      p_col_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we[p][c] |=> mem[$past(addr[p])][c*COL_W +: COL_W]
                      == $past(mem[addr[p]][c*COL_W +: COL_W]));
    end

    if (PMODE == RDW_NEW) begin : g_new_chk
      p_new_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_any[p] |=> rdata[p] == mem[$past(addr[p])]);
    end else begin : g_old_chk
      p_old_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_any[p] |=> rdata[p] == $past(mem[addr[p]]));
    end

    p_idle_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_any[p] |=> rdata[p] == $past(mem[addr[p]]));
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < N_PORTS; p++)
      if (wr_any[p]) mem[addr[p]] <= merged[p];
  end
endmodule

// File: tb/test_tdp_col_ram.sv
module test_tdp_col_ram;
  import tdp_ram_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NC = 4;
  localparam int DEPTH = 2**AW;
  localparam logic [DW-1:0] SCALAR = 16'h5A3C;

  function automatic logic [DW-1:0] init_word(int i);
    return 16'(16'hC300 + i * 37);
  endfunction

  function automatic logic [DEPTH*DW-1:0] mk_init();
    logic [DEPTH*DW-1:0] r;
    for (int i = 0; i < DEPTH; i++) r[i*DW +: DW] = init_word(i);
    return r;
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0] we_a, we_b;
  logic [AW-1:0] addr_a, addr_b, s_addr_a, s_addr_b;
  logic [DW-1:0] wd_a, wd_b, rd_a, rd_b, s_rd_a, s_rd_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdp_col_ram #(
    .ADDR_W(AW), .DATA_W(DW), .NUM_COLS(NC),
    .MODE_A(RDW_NEW), .MODE_B(RDW_OLD),
    .INIT_PER_WORD(1'b1), .INIT_SCALAR('0), .INIT_LIST(mk_init())
  ) i_tdp_col_ram (
    .clk_i(clk), .rst_ni(rst_n),
    .we_a_i(we_a), .addr_a_i(addr_a), .wdata_a_i(wd_a), .rdata_a_o(rd_a),
    .we_b_i(we_b), .addr_b_i(addr_b), .wdata_b_i(wd_b), .rdata_b_o(rd_b)
  );

  tdp_col_ram #(
    .ADDR_W(AW), .DATA_W(DW), .NUM_COLS(NC),
    .MODE_A(RDW_OLD), .MODE_B(RDW_NEW),
    .INIT_PER_WORD(1'b0), .INIT_SCALAR(SCALAR), .INIT_LIST('0)
  ) i_tdp_col_ram_scalar (
    .clk_i(clk), .rst_ni(rst_n),
    .we_a_i('0), .addr_a_i(s_addr_a), .wdata_a_i('0), .rdata_a_o(s_rd_a),
    .we_b_i('0), .addr_b_i(s_addr_b), .wdata_b_i('0), .rdata_b_o(s_rd_b)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] wd,
                                          logic [NC-1:0] en);
    logic [DW-1:0] r = old;
    for (int c = 0; c < NC; c++) if (en[c]) r[c*4 +: 4] = wd[c*4 +: 4];
    return r;
  endfunction

  // drive at negedge, one posedge later compare at the next negedge
  task automatic step(string tag);
    logic [DW-1:0] ea, eb, na, nb;
    na = merge(model[addr_a], wd_a, we_a);
    nb = merge(model[addr_b], wd_b, we_b);
    ea = (we_a != 0) ? na : model[addr_a];  // port A: NEW
    eb = model[addr_b];                     // port B: OLD
    model[addr_a] = na;
    model[addr_b] = nb;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " port A"}, rd_a, ea);
    chk({tag, " port B"}, rd_b, eb);
  endtask

  task automatic set_ports(logic [NC-1:0] wa, logic [AW-1:0] aa, logic [DW-1:0] da,
                           logic [NC-1:0] wb, logic [AW-1:0] ab, logic [DW-1:0] db);
    we_a = wa; addr_a = aa; wd_a = da;
    we_b = wb; addr_b = ab; wd_b = db;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0BAD_5EED));
    for (int i = 0; i < DEPTH; i++) model[i] = init_word(i);
    rst_n = 1'b0;
    set_ports('0, 4'd0, '0, '0, 4'd1, '0);
    s_addr_a = '0; s_addr_b = 4'd9;
    repeat (3) @(negedge clk);
    chk("R9 reset A", rd_a, '0);
    chk("R9 reset B", rd_b, '0);
    rst_n = 1'b1;

    // R7 per-word init at both address extremes
    set_ports('0, 4'd0, '0, '0, 4'd15, '0);
    s_addr_a = 4'd0; s_addr_b = 4'd15;
    step("R7 init");
    chk("R8 scalar A", s_rd_a, SCALAR);
    chk("R8 scalar B", s_rd_b, SCALAR);
    s_addr_a = 4'd7; s_addr_b = 4'd3;
    @(posedge clk); @(negedge clk);
    chk("R8 scalar A mid", s_rd_a, SCALAR);
    chk("R8 scalar B mid", s_rd_b, SCALAR);

    // R1 R10 simultaneous full writes, then cross read-back
    set_ports(4'hF, 4'd3, 16'h1234, 4'hF, 4'd12, 16'hBEEF);
    step("R10 R4 R5 dual write");
    set_ports('0, 4'd12, '0, '0, 4'd3, '0);
    step("R1 R2 cross read");

    // R3 partial column write on each port
    set_ports(4'b0101, 4'd3, 16'hAAAA, 4'b1000, 4'd12, 16'h0000);
    step("R3 R4 R5 column write");
    set_ports('0, 4'd12, '0, '0, 4'd3, '0);
    step("R3 read back");

    // R9 reset mid-run keeps contents
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 mid reset A", rd_a, '0);
    chk("R9 mid reset B", rd_b, '0);
    @(negedge clk);
    rst_n = 1'b1;
    set_ports('0, 4'd3, '0, '0, 4'd12, '0);
    step("R9 contents kept");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [AW-1:0] x;
      a = AW'($urandom);
      x = AW'(1 + ($urandom % (DEPTH - 1)));
      set_ports(($urandom % 4 == 0) ? '0 : NC'($urandom), a, DW'($urandom),
                ($urandom % 4 == 0) ? '0 : NC'($urandom), a ^ x, DW'($urandom));
      step((we_a == 0 && we_b == 0) ? "R6 R2 random idle" : "R3 R4 R5 random write");
    end

    // final sweep of every word with both ports idle
    for (int i = 0; i < DEPTH; i += 2) begin
      set_ports('0, AW'(i), '0, '0, AW'(i + 1), '0);
      step("R6 sweep");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule